// File: doc/BRIEF.md
# GPIO pad event interrupt controller

This block watches a bank of general-purpose pad inputs and turns configured input activity into interrupt and wake requests. Each pad has its own detection setting: it can react to a high level, a rising edge, both edges or nothing. A per-pad invert bit is applied before detection, which turns a rising edge into a falling edge and a high level into a low level. Pad inputs are first brought into the clock domain through two flip-flops.

Pads are numbered from zero and are grouped in banks of 24. A pad's bit position in a bank word is its number modulo 24, and its bank is its number divided by 24. Each detected event sets the pad's interrupt status bit and its wake status bit. Both are cleared by writing ones. The combined interrupt output is the OR over all pads of status AND interrupt enable. The wake output is the OR over all pads of wake status AND wake enable AND NOT the pad's route-to-firmware bit.

Software reaches everything through a plain register port. Writes are single-cycle strobes and reads are combinational. Bank words sit at 0x100 (interrupt status), 0x120 (interrupt enable), 0x140 (wake status) and 0x160 (wake enable), each plus 4 times the bank index. Pad configuration words sit at 0x400 plus 8 times the pad number.

Top module: `gpio_event_irq`

## Requirements
- R1: After reset, every status, enable, wake-status and wake-enable bit reads 0, and each pad configuration word reads 0x0400_0000 (detection mode 2, disabled) while its input is low.
- R2: A pad input change reaches detection after two clock edges, and an edge-mode status bit becomes readable after the third rising clock edge that follows the change.
- R3: Mode 0 (bits 26:25 of the configuration word) sets the status bit on every cycle the qualified input is high, so a write-1 clear takes no effect while the level persists.
- R4: Mode 1 latches a rising edge of the qualified input once and ignores a falling edge; with invert (bit 23) set, it latches falling edges instead.
- R5: Mode 3 latches both rising and falling edges of the raw input.
- R6: Mode 2 never sets the interrupt status or wake status bit, whatever the input does.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; writing 0xFFFF clears bits 15:0 only, and an event in the same cycle wins over the clear.
- R8: irq_o is high exactly when some pad has both its status bit (at 0x100+4*bank, bit pad mod 24) and its enable bit (at 0x120+4*bank, same bit) set.
- R9: Status bits at or above the pad count in the last bank, and bits 31:24 of every bank word, always read 0, and a configuration word for a pad number at or beyond the pad count reads 0.
- R10: An event also sets the wake status bit at 0x140+4*bank (write-1-to-clear); wake_o is high when some pad has wake status and wake enable (0x160+4*bank) set and its route bit (bit 19 of its configuration word) clear.
- R11: Bit 1 of each pad configuration word reads the synchronized pad input level and ignores writes.
- R12: Mode 0 with invert set latches while the input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Raw pad input levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
The assertions assume that any new status bit can come only from a detected event in the previous cycle. They also assume that irq_o and wake_o can only rise after an event or a register write. Both assumptions hold only if the register port is idle whenever reg_we is low, and only if pad inputs change nowhere but at the synchronizer. The stimulus drives pads and the register port a fraction of a nanosecond after each rising edge. It writes only mapped addresses and holds every pad level for at least four cycles, so each edge is seen once by the synchronizer.

// File: rtl/gpio_event_irq.sv
module gpio_event_irq #(
  parameter int NUM_PADS = 40,
  parameter int GRP_PADS = 24,
  parameter int AW       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_o,
  output logic                wake_o
);

  localparam int RW = AW - 5;
  localparam logic [RW-1:0] RG_STS  = RW'(8);
  localparam logic [RW-1:0] RG_IE   = RW'(9);
  localparam logic [RW-1:0] RG_WSTS = RW'(10);
  localparam logic [RW-1:0] RG_WEN  = RW'(11);
  localparam logic [1:0] M_LEVEL = 2'd0;
  localparam logic [1:0] M_EDGE  = 2'd1;
  localparam logic [1:0] M_OFF   = 2'd2;
  localparam logic [1:0] M_BOTH  = 2'd3;

  logic [RW-1:0] region;
  logic [2:0]    gsel;
  logic [RW-1:0] psel;
  logic          cfg_hit;

  assign region  = reg_addr[AW-1:5];
  assign gsel    = reg_addr[4:2];
  assign psel    = reg_addr[AW-3:3];
  assign cfg_hit = (reg_addr[AW-1:AW-2] == 2'b01) && !reg_addr[2];

  logic [NUM_PADS-1:0] evt_v, sts_q, ie_q, wsts_q, wen_q, sci_v;
  logic [31:0] cfg_rd [NUM_PADS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int G = p / GRP_PADS;
    localparam int B = p % GRP_PADS;

    logic [2:0] sy;
    logic [1:0] mode;
    logic       inv, sci, st, ws, ie, wen, e;
    logic       grp_hit, cfg_we, q, qp;

    assign grp_hit = (int'(gsel) == G);
    assign cfg_we  = reg_we && cfg_hit && (int'(psel) == p);
    assign q       = sy[1] ^ inv;
    assign qp      = sy[2] ^ inv;

    always_comb begin
      case (mode)
        M_LEVEL: e = q;
        M_EDGE:  e = q & ~qp;
        M_BOTH:  e = sy[1] ^ sy[2];
        default: e = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy   <= '0;
        mode <= M_OFF;
        inv  <= 1'b0;
        sci  <= 1'b0;
        st   <= 1'b0;
        ws   <= 1'b0;
        ie   <= 1'b0;
        wen  <= 1'b0;
      end else begin
        sy <= {sy[1:0], pad_i[p]};
        st <= (st & ~(reg_we && region == RG_STS  && grp_hit && reg_wdata[B])) | e;
        ws <= (ws & ~(reg_we && region == RG_WSTS && grp_hit && reg_wdata[B])) | e;
        if (reg_we && region == RG_IE  && grp_hit) ie  <= reg_wdata[B];
        if (reg_we && region == RG_WEN && grp_hit) wen <= reg_wdata[B];
        if (cfg_we) begin
          mode <= reg_wdata[26:25];
          inv  <= reg_wdata[23];
          sci  <= reg_wdata[19];
        end
      end
    end

    assign evt_v[p]  = e;
    assign sts_q[p]  = st;
    assign wsts_q[p] = ws;
    assign ie_q[p]   = ie;
    assign wen_q[p]  = wen;
    assign sci_v[p]  = sci;
    assign cfg_rd[p] = {5'b0, mode, 1'b0, inv, 3'b0, sci, 17'b0, sy[1], 1'b0};
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_hit) begin
      for (int p = 0; p < NUM_PADS; p++)
        if (int'(psel) == p) reg_rdata = cfg_rd[p];
    end else begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (p / GRP_PADS == int'(gsel)) begin
          case (region)
            RG_STS:  reg_rdata[p % GRP_PADS] = sts_q[p];
            RG_IE:   reg_rdata[p % GRP_PADS] = ie_q[p];
            RG_WSTS: reg_rdata[p % GRP_PADS] = wsts_q[p];
            RG_WEN:  reg_rdata[p % GRP_PADS] = wen_q[p];
            default: ;
          endcase
        end
      end
    end
  end

  assign irq_o  = |(sts_q & ie_q);
  assign wake_o = |(wsts_q & wen_q & ~sci_v);

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:27], reg_wdata[24], reg_addr[1:0]};

endmodule

// File: rtl/gpio_event_irq_chk.sv
module gpio_event_irq_chk #(
  parameter int NUM_PADS = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic                irq_o,
  input logic                wake_o,
  input logic [NUM_PADS-1:0] evt_v,
  input logic [NUM_PADS-1:0] sts_q
);

  a_r3_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_v != '0) |=> ((sts_q & $past(evt_v)) == $past(evt_v)));

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && evt_v == '0) |=> (sts_q == $past(sts_q)));

  a_r6_new_bits_need_event: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sts_q & ~$past(sts_q) & ~$past(evt_v)) == '0));

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(evt_v != '0 || reg_we));

  a_r10_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> $past(evt_v != '0 || reg_we));

endmodule

bind gpio_event_irq gpio_event_irq_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .reg_we (reg_we),
  .irq_o  (irq_o),
  .wake_o (wake_o),
  .evt_v  (evt_v),
  .sts_q  (sts_q)
);

// File: tb/sim_gpio_event_irq.sv
`timescale 1ns/100ps
module sim_gpio_event_irq;
  localparam int NP = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pads = '0;
  logic we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_o, wake_o;

  always #2.5 clk = ~clk;

  gpio_event_irq #(.NUM_PADS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_i(pads), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq_o), .wake_o(wake_o));

  int n_chk = 0;
  int n_fail = 0;

  bit m_s1[NP], m_s2[NP], m_s3[NP], m_inv[NP], m_sci[NP];
  bit m_sts[NP], m_ws[NP], m_ie[NP], m_wen[NP];
  bit [1:0] m_mode[NP];
  bit m_irq, m_wake;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int p = 0; p < NP; p++) begin
      m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0; m_inv[p] = 0; m_sci[p] = 0;
      m_sts[p] = 0; m_ws[p] = 0; m_ie[p] = 0; m_wen[p] = 0; m_mode[p] = 2'd2;
    end
    m_irq = 0; m_wake = 0;
  endfunction

  function automatic void model_step();
    for (int p = 0; p < NP; p++) begin
      int g = p / 24;
      int b = p % 24;
      bit q = m_s2[p] ^ m_inv[p];
      bit qp = m_s3[p] ^ m_inv[p];
      bit ev = 0;
      bit grp = (int'(addr[4:2]) == g);
      if (m_mode[p] == 0) ev = q;
      else if (m_mode[p] == 1) ev = q & !qp;
      else if (m_mode[p] == 3) ev = m_s2[p] ^ m_s3[p];
      if (we && grp && addr[11:5] == 7'd8 && wdata[b]) m_sts[p] = 0;
      if (we && grp && addr[11:5] == 7'd10 && wdata[b]) m_ws[p] = 0;
      if (ev) begin m_sts[p] = 1; m_ws[p] = 1; end
      if (we && grp && addr[11:5] == 7'd9)  m_ie[p] = wdata[b];
      if (we && grp && addr[11:5] == 7'd11) m_wen[p] = wdata[b];
      if (we && addr[11:10] == 2'b01 && int'(addr[9:3]) == p && !addr[2]) begin
        m_mode[p] = wdata[26:25]; m_inv[p] = wdata[23]; m_sci[p] = wdata[19];
      end
      m_s3[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pads[p];
    end
    m_irq = 0; m_wake = 0;
    for (int p = 0; p < NP; p++) begin
      if (m_sts[p] && m_ie[p]) m_irq = 1;
      if (m_ws[p] && m_wen[p] && !m_sci[p]) m_wake = 1;
    end
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #0.5;
      model_step();
      chk("R8 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R10 wake_o vs model", {31'b0, wake_o}, {31'b0, m_wake});
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; we = 0;
    #0.1;
    v = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    tick();
    we = 0;
  endtask

  task automatic cfg(input int p, input int mode, input bit inv, input bit sci);
    wr(12'(32'h400 + p * 8), (32'(mode) << 25) | (32'(inv) << 23) | (32'(sci) << 19));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    tick(2);

    rd(12'h100, v); chk("R1 status bank0", v, 0);
    rd(12'h120, v); chk("R1 enable bank0", v, 0);
    rd(12'h164, v); chk("R1 wake enable bank1", v, 0);
    rd(12'h400, v); chk("R1 cfg pad0", v, 32'h0400_0000);
    chk("R1 irq_o", {31'b0, irq_o}, 0);

    pads[5] = 1; tick();
    rd(12'h428, v); chk("R2 rx not yet synced", v, 32'h0400_0000);
    tick();
    rd(12'h428, v); chk("R11 rx level bit", v, 32'h0400_0002);
    wr(12'h428, 32'h0400_0000);
    rd(12'h428, v); chk("R11 rx ignores write", v, 32'h0400_0002);
    pads[5] = 0; tick(4);
    rd(12'h100, v); chk("R6 disabled status", v & 32'h20, 0);
    rd(12'h140, v); chk("R6 disabled wake status", v & 32'h20, 0);

    cfg(0, 1, 0, 0);
    pads[0] = 1; tick(2);
    rd(12'h100, v); chk("R2 edge after two edges", v & 1, 0);
    tick();
    rd(12'h100, v); chk("R4 rising latched", v & 1, 1);
    wr(12'h100, 1); tick(3);
    rd(12'h100, v); chk("R4 latched once", v & 1, 0);
    wr(12'h120, 1);
    chk("R8 enabled but no status", {31'b0, irq_o}, 0);
    pads[0] = 0; tick(4);
    rd(12'h100, v); chk("R4 falling ignored", v & 1, 0);
    pads[0] = 1; tick(4);
    rd(12'h100, v); chk("R4 rising again", v & 1, 1);
    chk("R8 irq high", {31'b0, irq_o}, 1);
    wr(12'h100, 0);
    rd(12'h100, v); chk("R7 write zero keeps", v & 1, 1);
    wr(12'h100, 1);
    rd(12'h100, v); chk("R7 write one clears", v & 1, 0);
    chk("R8 irq low after clear", {31'b0, irq_o}, 0);

    cfg(1, 1, 1, 0);
    pads[1] = 1; tick(4);
    rd(12'h100, v); chk("R4 inverted ignores rise", v & 2, 0);
    pads[1] = 0; tick(4);
    rd(12'h100, v); chk("R4 inverted falling", v & 2, 2);

    cfg(2, 0, 0, 0);
    pads[2] = 1; tick(4);
    rd(12'h100, v); chk("R3 level set", v & 4, 4);
    wr(12'h100, 4);
    rd(12'h100, v); chk("R3 clear blocked by level", v & 4, 4);
    pads[2] = 0; tick(4);
    wr(12'h100, 4);
    rd(12'h100, v); chk("R3 clear after level drops", v & 4, 0);

    cfg(3, 0, 1, 0);
    tick(2);
    rd(12'h100, v); chk("R12 active low", v & 8, 8);
    pads[3] = 1; tick(4);
    wr(12'h100, 8);
    rd(12'h100, v); chk("R12 cleared when high", v & 8, 0);

    cfg(4, 3, 0, 0);
    pads[4] = 1; tick(4);
    rd(12'h100, v); chk("R5 both rise", v & 16, 16);
    wr(12'h100, 16);
    pads[4] = 0; tick(4);
    rd(12'h100, v); chk("R5 both fall", v & 16, 16);

    cfg(20, 1, 0, 0);
    pads[20] = 1; pads[0] = 0; tick(4);
    pads[0] = 1; tick(4);
    rd(12'h100, v); chk("R7 two bits set", v & 32'h10_0001, 32'h10_0001);
    wr(12'h100, 32'h0000_FFFF);
    rd(12'h100, v); chk("R7 low half clear", v & 32'h10_0001, 32'h10_0000);

    cfg(39, 1, 0, 0);
    pads[39] = 1; tick(4);
    rd(12'h104, v); chk("R8 bank1 bit15", v & 32'h8000, 32'h8000);
    chk("R9 bank1 upper bits", v >> 16, 0);
    rd(12'h100, v); chk("R9 bank0 bits 31:24", v >> 24, 0);
    rd(12'h540, v); chk("R9 cfg beyond count", v, 0);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h104, v); chk("R7 bank1 cleared", v, 0);

    rd(12'h144, v); chk("R10 wake status", v & 32'h8000, 32'h8000);
    chk("R10 wake off without enable", {31'b0, wake_o}, 0);
    wr(12'h164, 32'h8000);
    chk("R10 wake on", {31'b0, wake_o}, 1);
    cfg(39, 1, 0, 1);
    chk("R10 route bit blocks wake", {31'b0, wake_o}, 0);
    cfg(39, 1, 0, 0);
    chk("R10 route bit cleared", {31'b0, wake_o}, 1);
    wr(12'h144, 32'h8000);
    chk("R10 wake status cleared", {31'b0, wake_o}, 0);

    tick(3);
    summary();
    $finish;
  end
endmodule